// File: doc/BRIEF.md
# GPIO Port Control Registers

This block is the register front end of one general-purpose I/O port with eight pads. A simple 32-bit register bus writes and reads it. The block holds the output level of each pad. Software can load those levels in one write, or change single bits through three write-only alias offsets that set, clear or toggle the selected bits without a read-modify-write.

Each pad has a 3-bit drive mode and an input-disable bit. The block turns the mode and the pad's current output bit into five pad-side controls: strong-low drive, strong-high drive, weak pull-up, weak pull-down and input-buffer enable. Pad input levels pass through a two-flop synchronizer. They can be read back from a read-only state register, where a pad whose input buffer is off reads 0.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the output levels, the drive modes and the input-disable bits are all 0. Every pad control output is therefore 0, and reads of offsets 0x00, 0x08 and 0x18 return 0.
- R2: Offset 0x00 holds the output levels, with bit i belonging to pad i. A write loads bits 7:0, and a read returns them with bits 31:8 as 0.
- R3: A write to offset 0x40 sets to 1 each output bit whose write-data bit is 1. All other output bits keep their value.
- R4: A write to offset 0x44 clears to 0 each output bit whose write-data bit is 1. All other output bits keep their value.
- R5: A write to offset 0x48 inverts each output bit whose write-data bit is 1. All other output bits keep their value.
- R6: Reads of offsets 0x40, 0x44 and 0x48 return 0.
- R7: Offset 0x08 holds the drive modes, with pad i in bits 3i+2..3i. A read returns them with bits 31:24 as 0.
- R8: Strong-low is active for a pad in mode 2, 4 or 6 whose output bit is 0. Strong-high is active for a pad in mode 3, 5 or 6 whose output bit is 1. Strong-low and strong-high are never active together.
- R9: The weak pull-up is active for a pad in mode 2 or 7 whose output bit is 1. The weak pull-down is active for a pad in mode 3 or 7 whose output bit is 0. Modes 0, 1, 4, 5 and 6 have no weak pull.
- R10: Offset 0x18 bit i disables the input buffer of pad i. The input-buffer enable of a pad is 1 exactly when its mode is not 0 and its disable bit is 0.
- R11: Offset 0x04 returns, for each pad, its input level after a two-flop synchronizer, ANDed with that pad's input-buffer enable.
- R12: A read returns its data with bus_rvalid in the cycle after the request. Writes to offset 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_drv_lo | output | 8 | Strong-low drive enable per pad |
| pad_drv_hi | output | 8 | Strong-high drive enable per pad |
| pad_pu | output | 8 | Weak pull-up enable per pad |
| pad_pd | output | 8 | Weak pull-down enable per pad |
| pad_ibuf_en | output | 8 | Input buffer enable per pad |

## Verification
The drive-mode decoder is tested with pad i set to mode i, so all eight modes are active in one configuration. It is tested under two complementary output patterns, which shows that each driver and pull follows the output bit and not only the mode. The set, clear and invert aliases are applied in a chain, each with a mask that overlaps both 0 and 1 bits of the current value. This tells a masked update apart from a plain load or from an operation on the wrong bits. The pad state register is read with all inputs high while half the pads are disabled, then with a mixed input pattern and all pads enabled, then with every pad in mode 0. These three reads separate the gating by input-disable from the gating by drive mode.

// File: rtl/gpio_port_pkg.sv
// Shared types and constants of the GPIO port control block.
// Assumes byte offsets fit in the bus address width chosen by the top.
package gpio_port_pkg;

    // Register byte offsets
    localparam int OFS_OUT     = 'h00;
    localparam int OFS_STATE   = 'h04;
    localparam int OFS_MODE    = 'h08;
    localparam int OFS_INDIS   = 'h18;
    localparam int OFS_OUT_SET = 'h40;
    localparam int OFS_OUT_CLR = 'h44;
    localparam int OFS_OUT_INV = 'h48;

    localparam int MODE_W = 3;

    // Drive mode encodings (value is behaviour-relevant)
    typedef enum logic [MODE_W-1:0] {
        DM_OFF     = 3'd0,
        DM_INPUT   = 3'd1,
        DM_LO_PU   = 3'd2,
        DM_PD_HI   = 3'd3,
        DM_LO_ONLY = 3'd4,
        DM_HI_ONLY = 3'd5,
        DM_LO_HI   = 3'd6,
        DM_PD_PU   = 3'd7
    } drv_mode_e;

    // Output register update operations
    typedef enum logic [1:0] {
        OUT_LOAD = 2'd0,
        OUT_SET  = 2'd1,
        OUT_CLR  = 2'd2,
        OUT_INV  = 2'd3
    } out_op_e;

    // Pad-side control bundle for one pad
    typedef struct packed {
        logic lo;
        logic hi;
        logic pu;
        logic pd;
        logic ib;
    } pad_ctl_t;

endpackage

// File: rtl/gpio_out_reg.sv
// Output level register of the port. Applies one update per cycle:
// a plain load or a masked set, clear or invert.
// Assumes the caller raises upd_en for at most one operation per cycle.
module gpio_out_reg
    import gpio_port_pkg::*;
#(
    parameter int N_PADS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  out_op_e           upd_op,
    input  logic [N_PADS-1:0] upd_data,
    output logic [N_PADS-1:0] out_q
);

    logic [N_PADS-1:0] out_next;

    // Next value for the selected update operation
    always_comb begin
        unique case (upd_op)
            OUT_LOAD: out_next = upd_data;
            OUT_SET:  out_next = out_q | upd_data;
            OUT_CLR:  out_next = out_q & ~upd_data;
            OUT_INV:  out_next = out_q ^ upd_data;
            default:  out_next = out_q;
        endcase
    end

    // Register the output levels, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (upd_en)
            out_q <= out_next;
    end

endmodule

// File: rtl/gpio_pad_decode.sv
// Turns each pad's drive mode, output bit and input-disable bit into
// pad controls. A driver or pull is active only when its level
// matches the output bit. Purely combinational.
module gpio_pad_decode
    import gpio_port_pkg::*;
#(
    parameter int N_PADS = 8,
    localparam int MODES_W = N_PADS * MODE_W
) (
    input  logic [MODES_W-1:0] modes,
    input  logic [N_PADS-1:0]  out_bits,
    input  logic [N_PADS-1:0]  in_dis,
    output logic [N_PADS-1:0]  drv_lo,
    output logic [N_PADS-1:0]  drv_hi,
    output logic [N_PADS-1:0]  pull_up,
    output logic [N_PADS-1:0]  pull_dn,
    output logic [N_PADS-1:0]  ibuf_en
);

    // Decode one pad from its mode, output level and disable bit
    function automatic pad_ctl_t decode_pad(input drv_mode_e m, input logic o, input logic dis);
        pad_ctl_t c;
        logic lo_cap, hi_cap, pu_cap, pd_cap;
        lo_cap = (m == DM_LO_PU) || (m == DM_LO_ONLY) || (m == DM_LO_HI);
        hi_cap = (m == DM_PD_HI) || (m == DM_HI_ONLY) || (m == DM_LO_HI);
        pu_cap = (m == DM_LO_PU) || (m == DM_PD_PU);
        pd_cap = (m == DM_PD_HI) || (m == DM_PD_PU);
        c.lo = lo_cap & ~o;
        c.hi = hi_cap & o;
        c.pu = pu_cap & o;
        c.pd = pd_cap & ~o;
        c.ib = (m != DM_OFF) & ~dis;
        return c;
    endfunction

    for (genvar i = 0; i < N_PADS; i++) begin : g_pad
        pad_ctl_t ctl;

        // Per-pad decode
        always_comb begin
            ctl = decode_pad(drv_mode_e'(modes[i*MODE_W +: MODE_W]), out_bits[i], in_dis[i]);
        end

        assign drv_lo[i]  = ctl.lo;
        assign drv_hi[i]  = ctl.hi;
        assign pull_up[i] = ctl.pu;
        assign pull_dn[i] = ctl.pd;
        assign ibuf_en[i] = ctl.ib;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for the asynchronous pad inputs.
// Assumes each pad is an independent level, so no bus coherency is needed.
module gpio_in_sync #(
    parameter int N_PADS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PADS-1:0] async_in,
    output logic [N_PADS-1:0] sync_out
);

    logic [N_PADS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One synchronizer stage, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= async_in;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
// Register block of one GPIO port. It decodes bus accesses, holds the
// drive modes and input-disable bits, and gives registered read data
// one cycle after a read request. Assumes at most one access per cycle.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int N_PADS = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int MODES_W = N_PADS * MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [N_PADS-1:0] pad_in,
    output logic [N_PADS-1:0] pad_drv_lo,
    output logic [N_PADS-1:0] pad_drv_hi,
    output logic [N_PADS-1:0] pad_pu,
    output logic [N_PADS-1:0] pad_pd,
    output logic [N_PADS-1:0] pad_ibuf_en
);

    logic                 wr, rd;
    logic                 hit_out, hit_state, hit_mode, hit_indis;
    logic                 hit_set, hit_clr, hit_inv;
    logic                 out_upd;
    out_op_e              out_op;
    logic [N_PADS-1:0]    out_q;
    logic [MODES_W-1:0]   mode_q;
    logic [N_PADS-1:0]    indis_q;
    logic [N_PADS-1:0]    pad_sync;
    logic [DATA_W-1:0]    rd_mux;
    logic [DATA_W-1:0]    rdata_q;
    logic                 rvalid_q;

    assign wr = bus_req & bus_we;
    assign rd = bus_req & ~bus_we;

    // Address decode of each register offset
    always_comb begin
        hit_out   = (bus_addr == ADDR_W'(OFS_OUT));
        hit_state = (bus_addr == ADDR_W'(OFS_STATE));
        hit_mode  = (bus_addr == ADDR_W'(OFS_MODE));
        hit_indis = (bus_addr == ADDR_W'(OFS_INDIS));
        hit_set   = (bus_addr == ADDR_W'(OFS_OUT_SET));
        hit_clr   = (bus_addr == ADDR_W'(OFS_OUT_CLR));
        hit_inv   = (bus_addr == ADDR_W'(OFS_OUT_INV));
    end

    // Select the output register operation for this write
    always_comb begin
        out_op = OUT_LOAD;
        if (hit_set)      out_op = OUT_SET;
        else if (hit_clr) out_op = OUT_CLR;
        else if (hit_inv) out_op = OUT_INV;
        out_upd = wr & (hit_out | hit_set | hit_clr | hit_inv);
    end

    gpio_out_reg #(.N_PADS(N_PADS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (out_upd),
        .upd_op   (out_op),
        .upd_data (bus_wdata[N_PADS-1:0]),
        .out_q    (out_q)
    );

    // Drive mode and input-disable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            indis_q <= '0;
        end else if (wr) begin
            if (hit_mode)  mode_q  <= bus_wdata[MODES_W-1:0];
            if (hit_indis) indis_q <= bus_wdata[N_PADS-1:0];
        end
    end

    gpio_pad_decode #(.N_PADS(N_PADS)) u_dec (
        .modes    (mode_q),
        .out_bits (out_q),
        .in_dis   (indis_q),
        .drv_lo   (pad_drv_lo),
        .drv_hi   (pad_drv_hi),
        .pull_up  (pad_pu),
        .pull_dn  (pad_pd),
        .ibuf_en  (pad_ibuf_en)
    );

    gpio_in_sync #(.N_PADS(N_PADS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    // Read data multiplexer; aliases and unmapped offsets read 0
    always_comb begin
        rd_mux = '0;
        if (hit_out)   rd_mux[N_PADS-1:0]  = out_q;
        if (hit_state) rd_mux[N_PADS-1:0]  = pad_sync & pad_ibuf_en;
        if (hit_mode)  rd_mux[MODES_W-1:0] = mode_q;
        if (hit_indis) rd_mux[N_PADS-1:0]  = indis_q;
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rd ? rd_mux : '0;
            rvalid_q <= rd;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
// Assertion checker for gpio_port_regs, attached with bind.
// Observes the bus, the pad controls and the output register.
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int N_PADS = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic [N_PADS-1:0] pad_drv_lo,
    input logic [N_PADS-1:0] pad_drv_hi,
    input logic [N_PADS-1:0] pad_pu,
    input logic [N_PADS-1:0] pad_pd,
    input logic [N_PADS-1:0] out_q
);

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(OFS_OUT_SET))
        |=> ((out_q & $past(bus_wdata[N_PADS-1:0])) == $past(bus_wdata[N_PADS-1:0])));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(OFS_OUT_CLR))
        |=> ((out_q & $past(bus_wdata[N_PADS-1:0])) == '0));

    // R8
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drv_lo & pad_drv_hi) == '0);

    // R9
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R9
    pull_vs_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_drv_hi) | (pad_pd & pad_drv_lo)) == '0);

    // R12
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .N_PADS (N_PADS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .pad_drv_lo (pad_drv_lo),
    .pad_drv_hi (pad_drv_hi),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd),
    .out_q      (out_q)
);

// File: tb/gpio_port_regs_tb_top.sv
// Scoreboard bench: read tasks queue expected data, a monitor pops and compares.
module gpio_port_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_drv_lo, pad_drv_hi, pad_pu, pad_pd, pad_ibuf_en;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_drv_lo(pad_drv_lo),
        .pad_drv_hi(pad_drv_hi), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_ibuf_en(pad_ibuf_en)
    );

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // Monitor: compare each returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected read data: got %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check_pads(input logic [7:0] lo, hi, pu, pd, ib, input string tag);
        n_vec++;
        if ({pad_drv_lo, pad_drv_hi, pad_pu, pad_pd, pad_ibuf_en} !== {lo, hi, pu, pd, ib}) begin
            n_bad++;
            $display("FAIL %s: got lo=%h hi=%h pu=%h pd=%h ib=%h expected lo=%h hi=%h pu=%h pd=%h ib=%h",
                     tag, pad_drv_lo, pad_drv_hi, pad_pu, pad_pd, pad_ibuf_en, lo, hi, pu, pd, ib);
        end
    endtask

    bit done = 0;

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_pads(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R1 pads after reset");
        bus_read(8'h00, 32'h0, "R1 out reg after reset");
        bus_read(8'h08, 32'h0, "R1 mode reg after reset");
        bus_read(8'h18, 32'h0, "R1 disable reg after reset");
        // R2 direct load
        bus_write(8'h00, 32'h0000_00A5);
        bus_read(8'h00, 32'hA5, "R2 load A5");
        bus_write(8'h00, 32'hFFFF_FF5A);
        bus_read(8'h00, 32'h5A, "R2 upper bits read 0");
        bus_write(8'h00, 32'h0000_00A5);
        // R3 set, R4 clear, R5 invert
        bus_write(8'h40, 32'h0F);
        bus_read(8'h00, 32'hAF, "R3 set alias");
        bus_write(8'h44, 32'hA0);
        bus_read(8'h00, 32'h0F, "R4 clear alias");
        bus_write(8'h48, 32'h3C);
        bus_read(8'h00, 32'h33, "R5 invert alias");
        // R6 alias reads
        bus_read(8'h40, 32'h0, "R6 set alias reads 0");
        bus_read(8'h44, 32'h0, "R6 clear alias reads 0");
        bus_read(8'h48, 32'h0, "R6 invert alias reads 0");
        // R7 pad i gets mode i
        bus_write(8'h08, 32'hFFFA_C688);
        bus_read(8'h08, 32'h00FA_C688, "R7 mode readback");
        // R8 R9 R10 decode with output 0x33
        check_pads(8'h44, 8'h20, 8'h00, 8'h88, 8'hFE, "R8 R9 R10 decode out=33");
        bus_write(8'h48, 32'hFF);
        check_pads(8'h10, 8'h48, 8'h84, 8'h00, 8'hFE, "R8 R9 R10 decode out=CC");
        // R10 input disable
        bus_write(8'h18, 32'h0F);
        check_pads(8'h10, 8'h48, 8'h84, 8'h00, 8'hF0, "R10 input disable");
        bus_read(8'h18, 32'h0F, "R10 disable readback");
        // R11 pad state
        @(negedge clk); pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        bus_read(8'h04, 32'hF0, "R11 state gated by disable");
        // R12 write to state ignored
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'hF0, "R12 state write ignored");
        bus_read(8'h00, 32'hCC, "R12 out unchanged by state write");
        bus_write(8'h18, 32'h00);
        @(negedge clk); pad_in = 8'h5B;
        repeat (2) @(negedge clk);
        bus_read(8'h04, 32'h5A, "R11 state pad0 mode 0 reads 0");
        bus_write(8'h08, 32'h0);
        bus_read(8'h04, 32'h00, "R11 state all mode 0");
        check_pads(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R10 all mode 0");
        repeat (3) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R12 missing read data: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule